// File: doc/BRIEF.md
# P-192 Fast Modular Reduction Unit

This unit folds a 384-bit integer, typically the double-width product of two 192-bit field elements, into its residue modulo p = 2^192 − 2^64 − 1. Because p has a sparse pseudo-Mersenne form, the fold needs no multiplier and no division. The input is cut into six 64-bit words, w0 least significant through w5 most significant. These words are recombined into four 192-bit terms, and the terms are summed.

All four terms go through one shared two-operand modular adder with a fixed latency of four cycles. A small sequencer issues exactly four adder operations in a fixed order, 16 cycles in total, and then publishes the residue with a one-cycle completion pulse. The first operation adds zero to the low term, which brings that term below p before the other terms are accumulated. A caller pulses `start` with the operand on `dataIn`, waits for `done`, and reads `result`. `result` holds its value until the next completion.

Top module: `p192_reducer`

## Requirements
- R1: While reset is asserted and after it is released, `done` is low and `result` is zero until the first completion.
- R2: `start` is sampled high while the unit is idle at clock edge S. Then `done` is high for exactly one cycle, set by edge S+17, and is low again after edge S+18.
- R3: At completion, `result` equals `dataIn` (as captured at the start edge, read as an unsigned 384-bit integer) modulo p, and is strictly less than p.
- R4: An input whose upper 192 bits are zero and whose low 192 bits are at least p gets p subtracted exactly once. The value p gives 0, and 2^192 − 1 gives 2^64.
- R5: Extreme operands are fully reduced. The all-ones 384-bit input gives its true residue, and (p−1)·(p−1) gives 1.
- R6: A `start` pulse, or a change of `dataIn`, while a reduction is in progress is ignored. The running reduction completes on its original cycle with the residue of the originally captured operand.
- R7: Between completions, `result` does not change, even while `dataIn` changes or a new reduction runs.
- R8: A `start` presented in the cycle in which `done` is high is accepted. The new reduction completes 17 cycles later with its own residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reduction; honoured only when idle |
| dataIn | input | 384 | Operand to reduce; captured on the accepted start edge |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 192 | Residue modulo p, held until the next completion |

## Verification
A sequencer whose step or term counter is wrong moves the completion pulse off its fixed cycle. This is visible at the first `done` after start, so the completion cycle is checked to the exact cycle on every reduction. A wrong word-to-term mapping changes the residue of an input that has only one word set, so each upper word is driven in isolation and compared on the first completion. A faulty final select in the adder leaves a value equal to or above p, or off by p. This shows on the same completion when the operand sits at or just above a multiple of p.

// File: rtl/p192_red_pkg.sv
package p192_red_pkg;
  // number of recombined terms and adder latency in cycles
  localparam int NTERMS     = 4;
  localparam int ADD_LAT    = 4;
  localparam int TERM_SEL_W = $clog2(NTERMS);
  localparam int STEP_W     = $clog2(ADD_LAT);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } redState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic                  load;     // capture operand
    logic                  go;       // issue one adder operation
    logic [TERM_SEL_W-1:0] termSel;  // which term enters the adder
    logic                  publish;  // copy accumulated sum to output
  } redCtrl_t;
endpackage

// File: rtl/p192_modadd.sv
// Two-operand adder modulo p = 2^F - 2^M - 1, fixed latency ADD_LAT.
// opA must be below p; opB may be any F-bit value.
module p192_modadd #(
  parameter int FIELD_W = 192,
  parameter int MID_EXP = 64,
  parameter int LIMB_W  = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               go,
  input  logic [FIELD_W-1:0] opA,
  input  logic [FIELD_W-1:0] opB,
  output logic [FIELD_W-1:0] sum
);
  localparam int NLIMB = FIELD_W / LIMB_W;
  localparam int EXT_W = FIELD_W + 2;
  // 2^F - p and 2*(2^F - p)
  localparam logic [EXT_W-1:0] COMP1 = (EXT_W'(1) << MID_EXP) | EXT_W'(1);
  localparam logic [EXT_W-1:0] COMP2 = COMP1 << 1;

  logic [FIELD_W-1:0] aR, bR;
  logic               v1, v2, v3;
  logic [FIELD_W:0]   c1R;
  logic [FIELD_W-1:0] c1Hold;
  logic [EXT_W-1:0]   c2R, c3R;
  logic [FIELD_W:0]   c1Next;
  logic [FIELD_W-1:0] selNext;

  // limb-wise ripple of the raw sum
  always_comb begin
    logic             cy;
    logic [LIMB_W:0]  part;
    cy = 1'b0;
    c1Next = '0;
    for (int i = 0; i < NLIMB; i++) begin
      part = {1'b0, aR[i*LIMB_W +: LIMB_W]} + {1'b0, bR[i*LIMB_W +: LIMB_W]}
           + {{LIMB_W{1'b0}}, cy};
      c1Next[i*LIMB_W +: LIMB_W] = part[LIMB_W-1:0];
      cy = part[LIMB_W];
    end
    c1Next[FIELD_W] = cy;
  end

  // pick raw sum, sum - p or sum - 2p
  always_comb begin
    if (c3R[EXT_W-1] && !c3R[FIELD_W])
      selNext = c3R[FIELD_W-1:0];
    else if (|c2R[EXT_W-1:FIELD_W])
      selNext = c2R[FIELD_W-1:0];
    else
      selNext = c1Hold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      aR <= '0; bR <= '0; c1R <= '0; c1Hold <= '0;
      c2R <= '0; c3R <= '0; sum <= '0;
    end else begin
      v1 <= go;
      v2 <= v1;
      v3 <= v2;
      if (go) begin
        aR <= opA;
        bR <= opB;
      end
      if (v1) c1R <= c1Next;
      if (v2) begin
        c2R    <= {1'b0, c1R} + COMP1;
        c3R    <= {1'b0, c1R} + COMP2;
        c1Hold <= c1R[FIELD_W-1:0];
      end
      if (v3) sum <= selNext;
    end
  end
endmodule

// File: rtl/p192_red_ctrl.sv
module p192_red_ctrl
  import p192_red_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output redCtrl_t ctl,
  output logic     done
);
  localparam logic [STEP_W-1:0]     LAST_STEP = STEP_W'(ADD_LAT - 1);
  localparam logic [TERM_SEL_W-1:0] LAST_OP   = TERM_SEL_W'(NTERMS - 1);

  redState_t             state;
  logic [STEP_W-1:0]     stepCnt;
  logic [TERM_SEL_W-1:0] opIdx;

  always_comb begin
    ctl.load    = (state == ST_IDLE) && start;
    ctl.go      = (state == ST_RUN) && (stepCnt == '0);
    ctl.termSel = opIdx;
    ctl.publish = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      opIdx   <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            stepCnt <= '0;
            opIdx   <= '0;
          end
        end
        ST_RUN: begin
          if (stepCnt == LAST_STEP) begin
            stepCnt <= '0;
            if (opIdx == LAST_OP) state <= ST_FIN;
            else opIdx <= opIdx + TERM_SEL_W'(1);
          end else begin
            stepCnt <= stepCnt + STEP_W'(1);
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/p192_red_dp.sv
module p192_red_dp
  import p192_red_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LIMB_W = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  redCtrl_t            ctl,
  input  logic [6*WORD_W-1:0] dataIn,
  output logic [3*WORD_W-1:0] result
);
  localparam int FIELD_W = 3 * WORD_W;
  localparam int IN_W    = 6 * WORD_W;

  logic [IN_W-1:0]    inReg;
  logic [WORD_W-1:0]  w [6];
  logic [FIELD_W-1:0] term [NTERMS];
  logic [FIELD_W-1:0] accSum, opA, opB;
  logic [WORD_W-1:0]  zw;

  assign zw = '0;

  for (genvar i = 0; i < 6; i++) begin : g_word
    assign w[i] = inReg[i*WORD_W +: WORD_W];
  end

  // recombination: weights 2^192 == 2^64 + 1 (mod p)
  assign term[0] = {w[2], w[1], w[0]};
  assign term[1] = {zw,   w[3], w[3]};
  assign term[2] = {w[4], w[4], zw};
  assign term[3] = {w[5], w[5], w[5]};

  // first pass normalises term 0 by adding zero
  assign opA = (ctl.termSel == '0) ? term[0] : accSum;
  assign opB = (ctl.termSel == '0) ? '0 : term[ctl.termSel];

  p192_modadd #(
    .FIELD_W(FIELD_W),
    .MID_EXP(WORD_W),
    .LIMB_W (LIMB_W)
  ) u_add (
    .clk (clk),
    .rstN(rstN),
    .go  (ctl.go),
    .opA (opA),
    .opB (opB),
    .sum (accSum)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg  <= '0;
      result <= '0;
    end else begin
      if (ctl.load)    inReg  <= dataIn;
      if (ctl.publish) result <= accSum;
    end
  end
endmodule

// File: rtl/p192_reducer.sv
module p192_reducer
  import p192_red_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LIMB_W = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [6*WORD_W-1:0] dataIn,
  output logic                done,
  output logic [3*WORD_W-1:0] result
);
  redCtrl_t ctl;

  p192_red_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctl  (ctl),
    .done (done)
  );

  p192_red_dp #(
    .WORD_W(WORD_W),
    .LIMB_W(LIMB_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .dataIn(dataIn),
    .result(result)
  );
endmodule

// File: rtl/p192_red_chk.sv
module p192_red_chk
  import p192_red_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                done,
  input logic [3*WORD_W-1:0] result
);
  localparam int FIELD_W = 3 * WORD_W;
  localparam logic [FIELD_W-1:0] P = {FIELD_W{1'b1}} - (FIELD_W'(1) << WORD_W);
  localparam int DUE   = NTERMS * ADD_LAT + 2;
  localparam int CNT_W = $clog2(DUE + 1);

  logic             pend;
  logic [CNT_W-1:0] cnt;

  // reference model of acceptance and elapsed cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= 1'b0;
      cnt  <= '0;
    end else if (pend && done) begin
      pend <= start;
      cnt  <= CNT_W'(1);
    end else if (pend) begin
      cnt <= cnt + CNT_W'(1);
    end else if (start) begin
      pend <= 1'b1;
      cnt  <= CNT_W'(1);
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2 R6
  done_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pend && cnt == CNT_W'(DUE)) |-> done);

  // R2 R6
  done_only_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pend && cnt == CNT_W'(DUE)));

  // R3
  result_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result < P));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));
endmodule

bind p192_reducer p192_red_chk #(.WORD_W(WORD_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .done  (done),
  .result(result)
);

// File: tb/sim_p192_reducer.sv
`timescale 1ns/1ps
module sim_p192_reducer;
  localparam int WORD_W  = 64;
  localparam int FIELD_W = 3 * WORD_W;
  localparam int IN_W    = 6 * WORD_W;
  localparam int LAT     = 18;   // negedges counted from the one after the start edge
  localparam logic [FIELD_W-1:0] P = {FIELD_W{1'b1}} - (FIELD_W'(1) << WORD_W);
  localparam logic [IN_W-1:0] P384 = {{FIELD_W{1'b0}}, P};
  localparam logic [IN_W-1:0] PM1  = P384 - IN_W'(1);
  localparam int NV = 12;
  localparam logic [IN_W-1:0] VEC [NV] = '{
    IN_W'(0),
    IN_W'(1),
    PM1,
    P384,
    {{FIELD_W{1'b0}}, {FIELD_W{1'b1}}},
    {IN_W{1'b1}},
    PM1 * PM1,
    {64'h0123456789abcdef, 64'hfedcba9876543210, 64'h0f1e2d3c4b5a6978,
     64'h8796a5b4c3d2e1f0, 64'hdeadbeefcafef00d, 64'h1357924680ace0bd},
    {128'd0, {WORD_W{1'b1}}, 192'd0},
    {64'd0, {WORD_W{1'b1}}, 256'd0},
    {{WORD_W{1'b1}}, 320'd0},
    P384 * P384
  };
  localparam string VTAG [NV] = '{
    "R3", "R3", "R3", "R4", "R4", "R5", "R5", "R3", "R3", "R3", "R3", "R3"
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IN_W-1:0] dataIn = '0;
  logic done;
  logic [FIELD_W-1:0] result;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  p192_reducer u0 (
    .clk(clk), .rstN(rstN), .start(start), .dataIn(dataIn),
    .done(done), .result(result)
  );

  function automatic logic [FIELD_W-1:0] refMod(input logic [IN_W-1:0] x);
    logic [IN_W-1:0] r;
    r = x % P384;
    return r[FIELD_W-1:0];
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [FIELD_W-1:0] act, input logic [FIELD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [IN_W-1:0] x);
    start  = 1'b1;
    dataIn = x;
    @(negedge clk);
    start = 1'b0;
  endtask

  // called at the negedge after the start edge (count 1)
  task automatic waitDone(input int from, output int lat);
    lat = from;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic runVec(input logic [IN_W-1:0] x, input string req);
    int lat;
    logic [FIELD_W-1:0] exp;
    exp = refMod(x);
    launch(x);
    waitDone(1, lat);
    check(lat == LAT, "R2 latency", FIELD_W'(lat), FIELD_W'(LAT));
    check(result == exp, req, result, exp);
    @(negedge clk);
    check(!done, "R2 pulse width", FIELD_W'(done), '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [FIELD_W-1:0] held;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!done, "R1 done in reset", FIELD_W'(done), '0);
    check(result == '0, "R1 result in reset", result, '0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!done, "R1 done after reset", FIELD_W'(done), '0);
    check(result == '0, "R1 result after reset", result, '0);

    for (int i = 0; i < NV; i++) begin
      runVec(VEC[i], VTAG[i]);
    end

    // R4 R5 explicit expected values
    runVec(P384, "R4 p gives zero");
    check(result == '0, "R4 p gives zero", result, '0);
    runVec({{FIELD_W{1'b0}}, {FIELD_W{1'b1}}}, "R4 top low half");
    check(result == (FIELD_W'(1) << WORD_W), "R4 top low half", result, FIELD_W'(1) << WORD_W);
    runVec(PM1 * PM1, "R5 square of p-1");
    check(result == FIELD_W'(1), "R5 square of p-1", result, FIELD_W'(1));

    // R6: second start and operand change while running
    launch(VEC[7]);
    @(negedge clk);
    start  = 1'b1;
    dataIn = VEC[5];
    @(negedge clk);
    start  = 1'b0;
    dataIn = VEC[6];
    waitDone(3, lat);
    check(lat == LAT, "R6 latency unchanged", FIELD_W'(lat), FIELD_W'(LAT));
    check(result == refMod(VEC[7]), "R6 original operand", result, refMod(VEC[7]));

    // R7: hold while idle and while a new reduction runs
    held = result;
    @(negedge clk);
    dataIn = VEC[10];
    repeat (4) @(negedge clk);
    check(result == held, "R7 hold idle", result, held);
    launch(VEC[9]);
    repeat (6) @(negedge clk);
    check(result == held, "R7 hold while running", result, held);
    waitDone(7, lat);
    check(result == refMod(VEC[9]), "R3 after hold", result, refMod(VEC[9]));

    // R8: start in the done cycle
    launch(VEC[8]);
    waitDone(1, lat);
    launch(VEC[10]);
    waitDone(1, lat);
    check(lat == LAT, "R8 latency", FIELD_W'(lat), FIELD_W'(LAT));
    check(result == refMod(VEC[10]), "R8 result", result, refMod(VEC[10]));
    @(negedge clk);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule